// File: doc/BRIEF.md
# Windowed Keyed Watchdog Timer

This block watches for a stalled or runaway program. It counts instruction-cycle ticks, which are marked by a one-cycle enable, and expects software to service it by writing an 8-bit service word. The count must lie inside a window when the write arrives. The window's lower edge is fixed. Its upper edge is picked by a two-bit field in the service word. Every service word must carry a fixed five-bit key. The first service word with a correct key sets the window choice and the clock-monitor enable, and both then stay fixed until the next reset. Every later service word must repeat the stored window bits and the key.

A violation is any of these:
- the count reaches the upper edge;
- a locked write arrives before the lower edge;
- a locked write has a mismatched word.

After a violation the block pulls its active-low output low. It keeps the output low until the sensed level of that line reads low, and then for a fixed number of further ticks. After that it releases the output. It waits for the sensed level to read high before it restarts the window count. The latched clock-monitor enable is brought out for a separate clock checker.

Top module: `svc_window_wdog`

## Requirements
- R1: While reset is held and right after it, `wd_out_n` is 1 and `cmon_en` is 1. The window select is 2'b11.
- R2: The service word layout is: bits 7:6 are the window select, bits 5:1 are the key, and bit 0 is the clock-monitor enable. The key is 5'b01100. The first write with this key since reset latches the window select and bit 0, and `cmon_en` takes bit 0 after the edge. This write counts as a service and restarts the count even if it arrives before the lower edge.
- R3: Before the lock, a write whose key is not 5'b01100 has no effect. The output, `cmon_en` and the running count are all unchanged.
- R4: Window selects 2'b00, 2'b01, 2'b10 and 2'b11 put the upper edge at UPPER_BASE, 2, 4 and 8 times UPPER_BASE ticks. When the count since the last restart reaches this edge, the output goes low on the following clock edge.
- R5: After the lock, a write whose bits 7:1 equal the stored window select and key, made when the count is at least LOWER_LIM, is a service. It restarts the count. Its bit 0 is ignored and `cmon_en` keeps its latched value.
- R6: After the lock, a matching write made when the count is below LOWER_LIM is a violation.
- R7: After the lock, a write with a window field that differs from the stored one, or a key other than 5'b01100, is a violation.
- R8: The output goes low on the clock edge that samples a violation. It stays low for as long as `pin_sense` reads 1. Once `pin_sense` is sampled 0, the output stays low for HOLD_CYC more ticks and is then released.
- R9: After the release, the count is held until `pin_sense` is sampled 1, so no timeout can occur while the line reads low. The count restarts from zero on the edge that samples it high.
- R10: A write made while the output is low, or while the block waits for the line to read high, is ignored. This holds even for a correct first write, which then latches nothing.
- R11: While `wd_off` is 1, the output is 1, no timeout occurs and writes are ignored. When `wd_off` returns to 0, the count starts again from zero.
- R12: The count advances only on clock edges where `cyc_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | One-cycle strobe marking an instruction-cycle tick |
| wd_off | input | 1 | Static disable: 1 turns the watchdog off |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service word: [7:6] window, [5:1] key, [0] clock-monitor enable |
| pin_sense | input | 1 | Sensed level of the watchdog output line |
| wd_out_n | output | 1 | Active-low watchdog event output |
| cmon_en | output | 1 | Latched clock-monitor enable |

## Verification
Most faults in the count show up as a timeout that is one or more cycles early or late. The bench samples the output on both sides of the expected edge, so such an error is seen within one clock of the correct trip point. A lock register that fails to hold, or a write that leaks through while the block is not armed, shows at `cmon_en` one edge after the write. It can also show as a trip at the next locked service. A trip sequencer in the wrong state lengthens or shortens the low pulse, or ends a hold early. This is visible within HOLD_CYC + 2 cycles of the violation.

// File: rtl/wdw_pkg.sv
// Shared types and constants for the windowed keyed watchdog.
// Assumes: service word layout is fixed at 8 bits (window, key, monitor).
package wdw_pkg;

    // Key value every service word must carry
    localparam logic [4:0] WDW_KEY = 5'b01100;

    // Service word as written by software
    typedef struct packed {
        logic [1:0] win;
        logic [4:0] key;
        logic       cmon;
    } wdw_word_t;

    // Trip sequencer states
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_TRIP  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_WAIT  = 2'd3
    } wdw_state_e;

endpackage

// File: rtl/wdw_cfg_lock.sv
// Write-once configuration and service-word classifier.
// Classifies each qualified write as a service or a violation. Latches the
// window and the monitor enable on the first keyed write after reset.
// Assumes: wr_stb is already qualified (armed, enabled).
module wdw_cfg_lock
    import wdw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  wdw_word_t   wr_word,
    input  logic        early,
    output logic [1:0]  win_sel,
    output logic        cmon_en,
    output logic        svc_ok,
    output logic        bad_wr
);

    logic locked;
    logic key_ok;
    logic first_ok;
    logic match;

    // Decode the incoming word against the key and the stored state
    always_comb begin
        key_ok   = (wr_word.key == WDW_KEY);
        first_ok = wr_stb & ~locked & key_ok;
        match    = locked & key_ok & (wr_word.win == win_sel);
        svc_ok   = first_ok | (wr_stb & match & ~early);
        bad_wr   = wr_stb & locked & ~(match & ~early);
    end

    // Latch the configuration once, on the first keyed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            win_sel <= 2'b11;
            cmon_en <= 1'b1;
        end else if (first_ok) begin
            locked  <= 1'b1;
            win_sel <= wr_word.win;
            cmon_en <= wr_word.cmon;
        end
    end

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(win_sel) && $stable(cmon_en)));

    // R3
    nolock_badkey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !locked && wr_word.key != WDW_KEY) |=> (!locked && $stable(cmon_en)));

    // R6
    early_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && locked && early) |-> (bad_wr && !svc_ok));

endmodule

// File: rtl/wdw_win_timer.sv
// Saturating window counter of instruction-cycle ticks.
// Flags a count below the lower edge (early) and at or above the selected
// upper edge (late).
// Assumes: the upper edges are UPPER_BASE << sel and fit in CNT_W bits.
module wdw_win_timer #(
    parameter int LOWER_LIM  = 2048,
    parameter int UPPER_BASE = 8192,
    parameter int CNT_W      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             clr,
    input  logic [1:0]       win_sel,
    output logic             early,
    output logic             late
);

    localparam int NUM_WIN = 4;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim [NUM_WIN];

    // One upper edge per window code
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_lim
        assign lim[g] = CNT_W'(UPPER_BASE * (1 << g));
    end

    // Count ticks, clearing on restart and saturating at full scale
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cyc_en && (cnt != {CNT_W{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Compare the count with both window edges
    always_comb begin
        early = (cnt < CNT_W'(LOWER_LIM));
        late  = (cnt >= lim[win_sel]);
    end

    // R12
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !clr) |=> $stable(cnt));

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/wdw_trip_fsm.sv
// Trip sequencer for the active-low watchdog line.
// Holds the line low until the sensed level is low, then for HOLD_CYC more
// ticks. After the release it waits for the sensed level to be high before
// re-arming.
// Assumes: HOLD_CYC >= 2; viol is only meaningful while armed.
module wdw_trip_fsm
    import wdw_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic wd_off,
    input  logic viol,
    input  logic pin_sense,
    output logic armed,
    output logic wd_out_n
);

    localparam int HOLD_W = $clog2(HOLD_CYC);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

    wdw_state_e      state;
    logic [HOLD_W-1:0] hold_cnt;

    // Step the trip sequence; the disable input forces the armed state
    always_ff @(posedge clk) begin
        if (!rst_n || wd_off) begin
            state    <= ST_ARMED;
            hold_cnt <= '0;
        end else begin
            case (state)
                ST_ARMED: if (viol) state <= ST_TRIP;
                ST_TRIP: if (!pin_sense) begin
                    state    <= ST_HOLD;
                    hold_cnt <= '0;
                end
                ST_HOLD: if (cyc_en) begin
                    if (hold_cnt == HOLD_LAST) state <= ST_WAIT;
                    else hold_cnt <= hold_cnt + 1'b1;
                end
                ST_WAIT: if (pin_sense) state <= ST_ARMED;
                default: state <= ST_ARMED;
            endcase
        end
    end

    // Decode the line drive and the armed flag from the state
    always_comb begin
        armed    = (state == ST_ARMED);
        wd_out_n = !((state == ST_TRIP) || (state == ST_HOLD));
    end

    // R8
    trip_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && viol && !wd_off) |=> !wd_out_n);

    // R8
    trip_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP && pin_sense && !wd_off) |=> (state == ST_TRIP));

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !pin_sense && !wd_off) |=> (wd_out_n && !armed));

    // R11
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off |=> (wd_out_n && armed));

endmodule

// File: rtl/svc_window_wdog.sv
// Top of the windowed keyed watchdog.
// Qualifies writes, merges the violation sources, and ties the counter, the
// configuration lock and the trip sequencer together.
// Assumes: cyc_en is a single-cycle tick in the clk domain; pin_sense is
// already synchronised.
module svc_window_wdog
    import wdw_pkg::*;
#(
    parameter int LOWER_LIM  = 2048,
    parameter int UPPER_BASE = 8192,
    parameter int HOLD_CYC   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_en,
    input  logic       wd_off,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       pin_sense,
    output logic       wd_out_n,
    output logic       cmon_en
);

    localparam int CNT_W = $clog2(UPPER_BASE) + 4;

    logic       armed;
    logic       wr_stb;
    logic       early;
    logic       late;
    logic       svc_ok;
    logic       bad_wr;
    logic       viol;
    logic       clr;
    logic [1:0] win_sel;
    wdw_word_t  wr_word;

    // Qualify writes and gather the restart and violation conditions
    always_comb begin
        wr_word = wdw_word_t'(wr_data);
        wr_stb  = wr_en & armed & ~wd_off;
        viol    = armed & ~wd_off & (bad_wr | late);
        clr     = ~armed | wd_off | svc_ok;
    end

    wdw_cfg_lock u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_word (wr_word),
        .early   (early),
        .win_sel (win_sel),
        .cmon_en (cmon_en),
        .svc_ok  (svc_ok),
        .bad_wr  (bad_wr)
    );

    wdw_win_timer #(
        .LOWER_LIM  (LOWER_LIM),
        .UPPER_BASE (UPPER_BASE),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_en  (cyc_en),
        .clr     (clr),
        .win_sel (win_sel),
        .early   (early),
        .late    (late)
    );

    wdw_trip_fsm #(
        .HOLD_CYC (HOLD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .wd_off    (wd_off),
        .viol      (viol),
        .pin_sense (pin_sense),
        .armed     (armed),
        .wd_out_n  (wd_out_n)
    );

    // R10
    idle_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed || wd_off) |=> $stable(cmon_en));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (wd_out_n && cmon_en));

endmodule

// File: tb/svc_window_wdog_test.sv
`timescale 1ns/1ps
module svc_window_wdog_test;

    localparam int LOWER = 32;
    localparam int BASE  = 64;
    localparam int HOLD  = 16;
    localparam logic [4:0] KEY = 5'b01100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b1;
    logic       wd_off = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       loop = 1'b1;
    logic       pin_force = 1'b1;
    logic       pin_sense;
    logic       wd_out_n;
    logic       cmon_en;

    typedef struct {
        logic  out;
        logic  cm;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   compared = 0;
    int   mismatched = 0;
    int   mcnt = 0;
    logic exp_cm = 1'b1;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    assign pin_sense = loop ? wd_out_n : pin_force;

    svc_window_wdog #(
        .LOWER_LIM  (LOWER),
        .UPPER_BASE (BASE),
        .HOLD_CYC   (HOLD)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .wd_off    (wd_off),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pin_sense (pin_sense),
        .wd_out_n  (wd_out_n),
        .cmon_en   (cmon_en)
    );

    // Monitor: compare outputs just after each edge against the queued item
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            compared++;
            if (wd_out_n !== it.out || cmon_en !== it.cm) begin
                mismatched++;
                $display("FAIL %s: wd_out_n=%b cmon_en=%b expected wd_out_n=%b cmon_en=%b",
                         it.tag, wd_out_n, cmon_en, it.out, it.cm);
            end
        end
    end

    function automatic logic [7:0] word(input logic [1:0] w, input logic [4:0] k, input logic c);
        return {w, k, c};
    endfunction

    // Driver: queue what the outputs must be after the next edge, then step
    task automatic step_exp(input logic o, input string tag);
        exp_t it;
        it.out = o;
        it.cm  = exp_cm;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        wr_en = 1'b0;
        if (cyc_en) mcnt++;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
        if (cyc_en) mcnt++;
    endtask

    task automatic run_to(input int n);
        while (mcnt < n) idle();
    endtask

    task automatic put(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
    endtask

    // Violation seen at the next edge, line looped back to the sense input
    task automatic trip_seq(input string tag);
        for (int i = 0; i <= HOLD; i++) step_exp(1'b0, tag);
        step_exp(1'b1, tag);
        step_exp(1'b1, tag);
        mcnt = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        wd_off = 1'b0;
        cyc_en = 1'b1;
        loop = 1'b1;
        pin_force = 1'b1;
        exp_cm = 1'b1;
        repeat (3) @(negedge clk);
        step_exp(1'b1, "R1 reset state");
        rst_n = 1'b1;
        mcnt = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 right after reset; R3 bad key before lock is ignored
        step_exp(1'b1, "R1 after release");
        run_to(10);
        put(word(2'b00, 5'b10101, 1'b0));
        step_exp(1'b1, "R3 bad key unlocked");
        // R4 default window 8*BASE counted from reset, not from the bad write
        run_to(8 * BASE - 1);
        step_exp(1'b1, "R4 sel11 before edge");
        loop = 1'b0;
        pin_force = 1'b1;
        step_exp(1'b0, "R8 trip after timeout");
        // R10 keyed first write during trip latches nothing
        put(word(2'b00, KEY, 1'b0));
        step_exp(1'b0, "R10 write in trip");
        for (int i = 0; i < 20; i++) step_exp(1'b0, "R8 held while line high");
        pin_force = 1'b0;
        for (int i = 0; i < HOLD; i++) step_exp(1'b0, "R8 hold after line low");
        step_exp(1'b1, "R8 release");
        put(word(2'b00, KEY, 1'b0));
        step_exp(1'b1, "R10 write while waiting");
        for (int i = 0; i < 8 * BASE + 40; i++) step_exp(1'b1, "R9 no timeout while line low");
        pin_force = 1'b1;
        step_exp(1'b1, "R9 rearm on line high");
        loop = 1'b1;
        mcnt = 0;
        // R2 first keyed write latches, counts as service below lower edge
        run_to(3);
        put(word(2'b00, KEY, 1'b0));
        exp_cm = 1'b0;
        step_exp(1'b1, "R2 first write latches");
        mcnt = 0;
        run_to(BASE - 1);
        step_exp(1'b1, "R4 sel00 before edge");
        trip_seq("R4 sel00 timeout");
        // R5 service at exactly the lower edge, bit 0 ignored
        run_to(LOWER);
        put(word(2'b00, KEY, 1'b1));
        step_exp(1'b1, "R5 service at lower edge");
        mcnt = 0;
        run_to(BASE - 1);
        step_exp(1'b1, "R5 restart after service");
        trip_seq("R5 timeout after service");
        // R6 one tick too early
        run_to(LOWER - 1);
        put(word(2'b00, KEY, 1'b0));
        trip_seq("R6 early service");
        // R7 window mismatch and key mismatch after lock
        run_to(40);
        put(word(2'b01, KEY, 1'b0));
        trip_seq("R7 window mismatch");
        run_to(40);
        put(word(2'b00, 5'b01101, 1'b0));
        trip_seq("R7 bad key locked");
        // R12 count frozen without ticks
        run_to(10);
        cyc_en = 1'b0;
        for (int i = 0; i < 200; i++) step_exp(1'b1, "R12 no tick no count");
        cyc_en = 1'b1;
        run_to(BASE - 1);
        step_exp(1'b1, "R12 edge after pause");
        trip_seq("R12 timeout after pause");
        // R11 disabled: no timeout, writes ignored, restart from zero
        wd_off = 1'b1;
        for (int i = 0; i < 100; i++) step_exp(1'b1, "R11 disabled");
        put(word(2'b11, 5'b00000, 1'b1));
        step_exp(1'b1, "R11 write while disabled");
        wd_off = 1'b0;
        mcnt = 0;
        run_to(BASE - 1);
        step_exp(1'b1, "R11 count from zero");
        trip_seq("R11 timeout after enable");
        // R4 window 2'b10 after a fresh reset
        do_reset();
        run_to(2);
        put(word(2'b10, KEY, 1'b1));
        step_exp(1'b1, "R2 lock sel10");
        mcnt = 0;
        run_to(4 * BASE - 1);
        step_exp(1'b1, "R4 sel10 before edge");
        trip_seq("R4 sel10 timeout");
        idle();
        idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog for a hung run
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule